// File: doc/BRIEF.md
# ADC Input Multiplexer Sequencer

This block steps the input multiplexer of a delta-sigma converter through a set of current-sensor channels in a repeating cycle. It is paced by a one-clock-wide tick taken from a 32768 Hz timebase. Each slot holds one channel for a fixed number of ticks. When a slot ends, the block issues a one-clock sample strobe that carries the index of the channel just converted.

A two-bit setting selects how many channels each cycle visits. A request input inserts a single extended cycle that appends a temperature-sensor slot after the last current channel. The block also drives the polarity of the reference chopper. In the automatic mode the polarity flips at every cycle start, extended cycles included. Two other modes hold it at regular or at inverted polarity. A one-clock sync pulse marks the start of each cycle, so that downstream consumers can align the fields they receive.

Top module: `adc_mux_seq`

## Requirements
- R1: While reset is asserted and after its release, before any tick arrives, `mux_sel` is 0 and `smp_valid`, `cyc_sync` and `chop_pol` are 0. The first cycle after reset visits six channels.
- R2: A slot lasts TICKS_PER_SLOT ticks (default 2). `mux_sel` changes only on the clock edge that samples the last tick of a slot, and it holds its value on every other edge.
- R3: On the edge that ends a slot, `smp_valid` goes high for exactly one clock, and `smp_chan` carries the `mux_sel` value of the slot that just ended.
- R4: `chan_cfg` gives the channel count: 2'b00 = 6 (codes 0..5), 2'b01 = 4 (codes 0..3), 2'b10 = 3 (codes 0..2), 2'b11 = 2 (codes 0..1). It is sampled only when a cycle starts, so a change in mid-cycle takes effect at the next cycle.
- R5: A one-clock pulse on `alt_req` is held pending until the next cycle start. That cycle then adds a temperature slot, code 6, after its last channel. The request is used once, and the cycle after it is normal again.
- R6: A request that arrives on the same clock edge as a cycle start applies to the cycle starting at that edge. It is consumed there and does not produce a second extended cycle.
- R7: With `chop_mode` 2'b00 or 2'b11 (automatic), `chop_pol` inverts at every cycle start, extended cycles included, and holds its value between cycle starts.
- R8: `chop_mode` 2'b01 forces `chop_pol` to 0 and 2'b10 forces it to 1, from the clock after the mode is applied, whatever the cycle boundaries do.
- R9: `cyc_sync` is high for exactly one clock, in the same clock as the strobe of a cycle's last slot. While it is high, `mux_sel` already shows code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_tick | input | 1 | One-clock pulse per 32768 Hz period |
| chan_cfg | input | 2 | Channel-count code, sampled at each cycle start |
| alt_req | input | 1 | Pulse that requests one extended cycle with the temperature slot |
| chop_mode | input | 2 | Chopper mode: automatic, forced regular or forced inverted |
| mux_sel | output | SEL_W | Code of the input currently routed to the converter |
| smp_valid | output | 1 | One-clock strobe at the end of each slot |
| smp_chan | output | SEL_W | Code of the slot that just ended, valid with `smp_valid` |
| chop_pol | output | 1 | Reference chopper polarity |
| cyc_sync | output | 1 | One-clock pulse at each cycle start |

## Verification
The functions that can land in the same clock are an arriving extended-cycle request and the cycle boundary that would consume it. The bench provokes this case by watching its own reference model and raising `alt_req` on exactly the clock whose tick closes the last slot of a cycle. It then judges the outcome from the temperature strobes: exactly one must follow, in the cycle that starts at that edge, and no repeat may come after it. A chopper flip and a forced-mode change can also meet at a boundary, and the clock-by-clock comparison of `chop_pol` covers that case.

// File: rtl/adc_mux_pkg.sv
package adc_mux_pkg;
   typedef enum logic [1:0] {
      CNT_SEL_A = 2'b00,
      CNT_SEL_B = 2'b01,
      CNT_SEL_C = 2'b10,
      CNT_SEL_D = 2'b11
   } cnt_sel_e;

   typedef enum logic [1:0] {
      CHOP_TOGGLE     = 2'b00,
      CHOP_FORCE_POS  = 2'b01,
      CHOP_FORCE_REV  = 2'b10,
      CHOP_TOGGLE_ALT = 2'b11
   } chop_mode_e;
endpackage

// File: rtl/adc_mux_slot_timer.sv
module adc_mux_slot_timer #(
   parameter int TICKS_PER_SLOT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic slot_end
);
   localparam int CW = (TICKS_PER_SLOT > 1) ? $clog2(TICKS_PER_SLOT) : 1;

   generate
      if (TICKS_PER_SLOT == 1) begin : g_single
         logic unused_ok;
         assign unused_ok = clk ^ rst_n;
         assign slot_end  = tick;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (tick) begin
               if (cnt_q == CW'(TICKS_PER_SLOT - 1)) cnt_q <= '0;
               else                                  cnt_q <= cnt_q + CW'(1);
            end
         end
         assign slot_end = tick && (cnt_q == CW'(TICKS_PER_SLOT - 1));
      end
   endgenerate
endmodule

// File: rtl/adc_mux_chan_stepper.sv
module adc_mux_chan_stepper
   import adc_mux_pkg::*;
#(
   parameter int SEL_W     = 3,
   parameter int CNT_A     = 6,
   parameter int CNT_B     = 4,
   parameter int CNT_C     = 3,
   parameter int CNT_D     = 2,
   parameter int TEMP_CODE = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slot_end,
   input  logic [1:0]       chan_cfg,
   input  logic             alt_req,
   output logic [SEL_W-1:0] cur_sel,
   output logic             cyc_start
);
   logic [SEL_W-1:0] slot_q;
   logic [SEL_W-1:0] cnt_q;
   logic [SEL_W-1:0] cnt_sel;
   logic             ext_q;
   logic             pend_q;
   logic             last_slot;
   logic             take_ext;

   always_comb begin
      unique case (cnt_sel_e'(chan_cfg))
         CNT_SEL_A: cnt_sel = SEL_W'(CNT_A);
         CNT_SEL_B: cnt_sel = SEL_W'(CNT_B);
         CNT_SEL_C: cnt_sel = SEL_W'(CNT_C);
         CNT_SEL_D: cnt_sel = SEL_W'(CNT_D);
      endcase
   end

   assign last_slot = ext_q ? (slot_q == cnt_q) : (slot_q == cnt_q - SEL_W'(1));
   assign cyc_start = slot_end && last_slot;
   assign take_ext  = pend_q || alt_req;
   assign cur_sel   = (ext_q && (slot_q == cnt_q)) ? SEL_W'(TEMP_CODE) : slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
         cnt_q  <= SEL_W'(CNT_A);
         ext_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         pend_q <= cyc_start ? 1'b0 : (pend_q || alt_req);
         if (slot_end) begin
            if (last_slot) begin
               slot_q <= '0;
               cnt_q  <= cnt_sel;
               ext_q  <= take_ext;
            end else begin
               slot_q <= slot_q + SEL_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/adc_mux_chop_ctrl.sv
module adc_mux_chop_ctrl
   import adc_mux_pkg::*;
#(
   parameter bit RESET_POL = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cyc_start,
   input  logic [1:0] mode,
   output logic       chop_pol
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chop_pol <= RESET_POL;
      end else begin
         unique case (chop_mode_e'(mode))
            CHOP_FORCE_POS:  chop_pol <= 1'b0;
            CHOP_FORCE_REV:  chop_pol <= 1'b1;
            CHOP_TOGGLE,
            CHOP_TOGGLE_ALT: if (cyc_start) chop_pol <= !chop_pol;
         endcase
      end
   end
endmodule

// File: rtl/adc_mux_seq.sv
module adc_mux_seq #(
   parameter int TICKS_PER_SLOT = 2,
   parameter int SEL_W          = 3,
   parameter int CNT_A          = 6,
   parameter int CNT_B          = 4,
   parameter int CNT_C          = 3,
   parameter int CNT_D          = 2,
   parameter int TEMP_CODE      = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slot_tick,
   input  logic [1:0]       chan_cfg,
   input  logic             alt_req,
   input  logic [1:0]       chop_mode,
   output logic [SEL_W-1:0] mux_sel,
   output logic             smp_valid,
   output logic [SEL_W-1:0] smp_chan,
   output logic             chop_pol,
   output logic             cyc_sync
);
   localparam int CODE_SPACE = 1 << SEL_W;

   generate
      if (TICKS_PER_SLOT < 1) begin : g_bad_ticks
         $error("TICKS_PER_SLOT must be at least 1");
      end
      if (TEMP_CODE >= CODE_SPACE) begin : g_bad_temp_w
         $error("TEMP_CODE does not fit in SEL_W bits");
      end
      if (TEMP_CODE < CNT_A || TEMP_CODE < CNT_B || TEMP_CODE < CNT_C || TEMP_CODE < CNT_D) begin : g_bad_temp
         $error("TEMP_CODE collides with a channel code");
      end
      if (CNT_A < 1 || CNT_B < 1 || CNT_C < 1 || CNT_D < 1) begin : g_bad_cnt
         $error("every channel count must be at least 1");
      end
   endgenerate

   logic slot_end;
   logic cyc_start;

   adc_mux_slot_timer #(.TICKS_PER_SLOT(TICKS_PER_SLOT)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (slot_tick),
      .slot_end (slot_end)
   );

   adc_mux_chan_stepper #(
      .SEL_W(SEL_W), .CNT_A(CNT_A), .CNT_B(CNT_B), .CNT_C(CNT_C),
      .CNT_D(CNT_D), .TEMP_CODE(TEMP_CODE)
   ) u_step (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_end  (slot_end),
      .chan_cfg  (chan_cfg),
      .alt_req   (alt_req),
      .cur_sel   (mux_sel),
      .cyc_start (cyc_start)
   );

   adc_mux_chop_ctrl #(.RESET_POL(1'b0)) u_chop (
      .clk       (clk),
      .rst_n     (rst_n),
      .cyc_start (cyc_start),
      .mode      (chop_mode),
      .chop_pol  (chop_pol)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_valid <= 1'b0;
         smp_chan  <= '0;
         cyc_sync  <= 1'b0;
      end else begin
         smp_valid <= slot_end;
         cyc_sync  <= cyc_start;
         if (slot_end) smp_chan <= mux_sel;
      end
   end
endmodule

// File: rtl/adc_mux_seq_chk.sv
module adc_mux_seq_chk #(
   parameter int SEL_W     = 3,
   parameter int CNT_A     = 6,
   parameter int TEMP_CODE = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             slot_tick,
   input logic [1:0]       chop_mode,
   input logic [SEL_W-1:0] mux_sel,
   input logic             smp_valid,
   input logic [SEL_W-1:0] smp_chan,
   input logic             chop_pol,
   input logic             cyc_sync
);
   AST_SEL_HOLDS_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(slot_tick) |-> $stable(mux_sel)) else $error("mux_sel moved without tick"); // R2
   AST_STROBE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> !smp_valid) else $error("strobe wider than one clock"); // R3
   AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (mux_sel < SEL_W'(CNT_A)) || (mux_sel == SEL_W'(TEMP_CODE))) else $error("illegal select code"); // R4
   AST_TEMP_CLOSES_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && smp_chan == SEL_W'(TEMP_CODE)) |-> cyc_sync) else $error("temperature slot not last"); // R5
   AST_AUTO_CHOP_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_sync && ($past(chop_mode) == 2'b00 || $past(chop_mode) == 2'b11)) |-> (chop_pol != $past(chop_pol)))
      else $error("chop did not flip"); // R7
   AST_FORCE_REGULAR: assert property (@(posedge clk) disable iff (!rst_n)
      (chop_mode == 2'b01) |=> !chop_pol) else $error("forced regular ignored"); // R8
   AST_FORCE_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
      (chop_mode == 2'b10) |=> chop_pol) else $error("forced inverted ignored"); // R8
   AST_SYNC_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_sync |=> !cyc_sync) else $error("sync wider than one clock"); // R9
   AST_SYNC_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_sync |-> (smp_valid && mux_sel == '0)) else $error("sync misaligned"); // R9
endmodule

bind adc_mux_seq adc_mux_seq_chk #(.SEL_W(SEL_W), .CNT_A(CNT_A), .TEMP_CODE(TEMP_CODE)) u_chk (.*);

// File: tb/test_adc_mux_seq.sv
module test_adc_mux_seq;
   localparam int CLK_PERIOD = 10;
   localparam int TPS        = 2;
   localparam int TICK_GAP   = 3;
   localparam int TEMP       = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       slot_tick = 1'b0;
   logic [1:0] chan_cfg = 2'b00;
   logic       alt_req = 1'b0;
   logic [1:0] chop_mode = 2'b00;
   logic [2:0] mux_sel;
   logic       smp_valid;
   logic [2:0] smp_chan;
   logic       chop_pol;
   logic       cyc_sync;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  tick_en = 0;
   bit  arm_mid = 0;
   bit  arm_edge = 0;
   bit  cmp_on = 0;
   int  gap_cnt = 0;
   int  temp_cnt = 0;

   // reference model state
   int q[$];
   int m_ticks, m_pend, m_chop, e_valid, e_chan, e_sync;

   adc_mux_seq i_adc_mux_seq (
      .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .chan_cfg(chan_cfg),
      .alt_req(alt_req), .chop_mode(chop_mode), .mux_sel(mux_sel),
      .smp_valid(smp_valid), .smp_chan(smp_chan), .chop_pol(chop_pol),
      .cyc_sync(cyc_sync)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int count_of(input logic [1:0] c);
      case (c)
         2'b00: return 6;
         2'b01: return 4;
         2'b10: return 3;
         default: return 2;
      endcase
   endfunction

   // behavioural reference: a queue of channel codes still to visit
   always @(posedge clk) begin
      if (!rst_n) begin
         q = {0, 1, 2, 3, 4, 5};
         m_ticks = 0; m_pend = 0; m_chop = 0;
         e_valid = 0; e_chan = 0; e_sync = 0;
      end else begin
         e_valid = 0; e_sync = 0;
         if (alt_req) m_pend = 1;
         if (chop_mode == 2'b01) m_chop = 0;
         else if (chop_mode == 2'b10) m_chop = 1;
         if (slot_tick) begin
            m_ticks++;
            if (m_ticks == TPS) begin
               m_ticks = 0;
               e_valid = 1;
               e_chan = q.pop_front();
               if (q.size() == 0) begin
                  for (int i = 0; i < count_of(chan_cfg); i++) q.push_back(i);
                  if (m_pend != 0) q.push_back(TEMP);
                  m_pend = 0;
                  e_sync = 1;
                  if (chop_mode == 2'b00 || chop_mode == 2'b11) m_chop = 1 - m_chop;
               end
            end
         end
      end
   end

   // tick and request generator, driven away from the active edge
   always @(negedge clk) begin
      slot_tick = 1'b0;
      alt_req = 1'b0;
      if (tick_en) begin
         gap_cnt++;
         if (gap_cnt == TICK_GAP) begin
            gap_cnt = 0;
            slot_tick = 1'b1;
         end
      end
      if (arm_mid) begin
         alt_req = 1'b1;
         arm_mid = 0;
      end
      if (arm_edge && slot_tick && q.size() == 1 && m_ticks == TPS - 1) begin
         alt_req = 1'b1;
         arm_edge = 0;
      end
   end

   // clock-by-clock comparison against the model
   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         check(int'(mux_sel) == q[0], "R2 R4 mux_sel", int'(mux_sel), q[0]);
         check(int'(smp_valid) == e_valid, "R3 smp_valid", int'(smp_valid), e_valid);
         if (e_valid != 0)
            check(int'(smp_chan) == e_chan, "R3 smp_chan", int'(smp_chan), e_chan);
         check(int'(cyc_sync) == e_sync, "R9 cyc_sync", int'(cyc_sync), e_sync);
         check(int'(chop_pol) == m_chop,
               (chop_mode == 2'b01 || chop_mode == 2'b10) ? "R8 chop_pol" : "R7 chop_pol",
               int'(chop_pol), m_chop);
         if (smp_valid && smp_chan == 3'(TEMP)) temp_cnt++;
      end
   end

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      run(4);
      check(mux_sel == 3'd0, "R1 reset mux_sel", int'(mux_sel), 0);
      check(smp_valid == 1'b0, "R1 reset smp_valid", int'(smp_valid), 0);
      check(cyc_sync == 1'b0, "R1 reset cyc_sync", int'(cyc_sync), 0);
      check(chop_pol == 1'b0, "R1 reset chop_pol", int'(chop_pol), 0);
      rst_n = 1'b1;
      run(3);
      check(mux_sel == 3'd0, "R1 idle mux_sel", int'(mux_sel), 0);
      cmp_on = 1;
      chan_cfg = 2'b01;          // R1: first cycle still six slots
      tick_en = 1;
      run(130);
      run(17);  chan_cfg = 2'b10; // R4: mid-cycle change
      run(100); chan_cfg = 2'b11;
      run(80);  chan_cfg = 2'b00;
      run(90);
      chan_cfg = 2'b01;
      run(30);
      // R5: request in mid-cycle gives one extended cycle
      temp_cnt = 0;
      arm_mid = 1;
      run(200);
      check(temp_cnt == 1, "R5 temperature slots", temp_cnt, 1);
      // R6: request on the boundary edge
      temp_cnt = 0;
      arm_edge = 1;
      run(200);
      check(arm_edge == 0, "R6 boundary request issued", int'(arm_edge), 0);
      check(temp_cnt == 1, "R6 temperature slots", temp_cnt, 1);
      // R8: forced polarities, then automatic again with an extended cycle
      chop_mode = 2'b01; run(100);
      check(chop_pol == 1'b0, "R8 forced regular", int'(chop_pol), 0);
      chop_mode = 2'b10; run(100);
      check(chop_pol == 1'b1, "R8 forced inverted", int'(chop_pol), 1);
      chop_mode = 2'b11; chan_cfg = 2'b11;
      temp_cnt = 0; arm_mid = 1;
      run(120);
      check(temp_cnt == 1, "R7 R5 extended cycle in auto chop", temp_cnt, 1);
      chop_mode = 2'b00; chan_cfg = 2'b10;
      run(90);
      tick_en = 0;
      run(10);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule